// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Saturation

This block keeps a 64-bit accumulator, presented as a high word and a low word, and updates it from two 32-bit operands. Four operations are offered. Two are plain double-width multiplies, one signed and one unsigned, that overwrite the accumulator. One is a signed 32x32 multiply-accumulate. The last is a signed 16x16 multiply-accumulate on the low halves of the operands. A saturation-mode input changes how the two accumulate forms clip their result, and each form uses its own clipping rule.

An operation is requested with a one-cycle start strobe. The operands, the operation code and the saturation mode are captured in that cycle. The product is registered in the next cycle, and the accumulator is written in the cycle after that. A clear strobe zeroes the accumulator in one cycle at any time. It takes priority over a result being written in the same cycle.

Top module: `mac_unit`

## Requirements
- R1: While reset is asserted, both accumulator words read 0, and busy and done are both 0.
- R2: Operation code 0 (signed multiply) writes the 64-bit two's-complement product of the operands. Bits 63:32 go to the high word and bits 31:0 go to the low word. The saturation input has no effect on this operation.
- R3: Operation code 1 (unsigned multiply) writes the 64-bit unsigned product of the operands, split across the two words in the same way.
- R4: Operation code 2 (32-bit accumulate) adds the signed 64-bit product of the operands to the accumulator {high, low}. With saturation off, the sum wraps modulo 2^64.
- R5: With saturation on, operation code 2 adjusts the high word after the add. A negative sum sets high-word bits 31:16 to ones. A non-negative sum clears high-word bits 31:15. The low word keeps the sum.
- R6: Operation code 3 (16-bit accumulate) multiplies the sign-extended bits 15:0 of each operand and adds the product to the accumulator. Bits 31:16 of the operands are ignored. With saturation off, the sum wraps modulo 2^64.
- R7: With saturation on, an operation code 3 sum below -2^31 leaves high = 1 and low = 0x80000000.
- R8: With saturation on, an operation code 3 sum above 2^31-1 leaves high = 1 and low = 0x7FFFFFFF. A sum inside the range is stored unchanged.
- R9: A clear strobe makes both words 0 after the next clock edge. This holds even when a result would be written at that edge. A clear taken while an operation is in flight makes a pending accumulate add its product to zero.
- R10: An accepted start drives busy high for exactly two cycles. The operands, code and saturation mode are sampled only in the start cycle. The accumulator is written when busy falls, and done is high for exactly that one cycle.
- R11: A start while busy is ignored. It produces no further busy period, no done pulse and no change to the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the unit is idle |
| clear_i | input | 1 | Zeroes both accumulator words |
| op_i | input | 2 | Operation code: 0 signed multiply, 1 unsigned multiply, 2 32-bit accumulate, 3 16-bit accumulate |
| sat_i | input | 1 | Saturation mode for the accumulate forms |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| acc_hi_o | output | 32 | Accumulator bits 63:32 |
| acc_lo_o | output | 32 | Accumulator bits 31:0 |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle pulse when the accumulator is written |

## Verification
Two functions can meet in one cycle: the clear strobe and the accumulator write of an operation in flight. The bench raises clear in the cycle in which the write edge falls, and expects both words to read zero while done still pulses. It also raises clear one cycle earlier, in the product cycle, and expects the accumulate to store the bare product. A scoreboard compares every done pulse against a model that applies these rules.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_SMUL = 2'd0,
    OP_UMUL = 2'd1,
    OP_MAC  = 2'd2,
    OP_MACH = 2'd3
  } mac_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MUL  = 2'd1,
    PH_ACC  = 2'd2
  } mac_phase_e;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic cap_o,
  output logic mul_o,
  output logic wr_o,
  output logic busy_o,
  output logic done_o
);
  mac_phase_e phase_q, phase_d;
  logic       done_q;

  assign cap_o  = start_i && (phase_q == PH_IDLE);
  assign mul_o  = (phase_q == PH_MUL);
  assign wr_o   = (phase_q == PH_ACC);
  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = done_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_MUL;
      PH_MUL:  phase_d = PH_ACC;
      PH_ACC:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= wr_o;
    end
  end
endmodule

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic            mul_i,
  input  mac_op_e         op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output mac_op_e         op_o,
  output logic [2*DW-1:0] prod_o
);
  localparam int HW = DW / 2;
  localparam int EW = DW + 1;
  localparam int PW = 2 * EW;

  logic [DW-1:0]   a_q, b_q;
  mac_op_e         op_q;
  logic [EW-1:0]   ea, eb;
  logic [PW-1:0]   wa, wb, p_full;
  logic [2*DW-1:0] prod_q;

  // one widened multiplier covers signed, unsigned and half-width forms
  always_comb begin
    unique case (op_q)
      OP_UMUL: begin
        ea = {1'b0, a_q};
        eb = {1'b0, b_q};
      end
      OP_MACH: begin
        ea = {{(EW-HW){a_q[HW-1]}}, a_q[HW-1:0]};
        eb = {{(EW-HW){b_q[HW-1]}}, b_q[HW-1:0]};
      end
      default: begin
        ea = {a_q[DW-1], a_q};
        eb = {b_q[DW-1], b_q};
      end
    endcase
  end

  assign wa     = {{EW{ea[EW-1]}}, ea};
  assign wb     = {{EW{eb[EW-1]}}, eb};
  assign p_full = wa * wb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      op_q   <= OP_SMUL;
      prod_q <= '0;
    end else begin
      if (cap_i) begin
        a_q  <= a_i;
        b_q  <= b_i;
        op_q <= op_i;
      end
      if (mul_i) prod_q <= p_full[2*DW-1:0];
    end
  end

  assign op_o   = op_q;
  assign prod_o = prod_q;
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  mac_op_e         op_i,
  input  logic            sat_i,
  input  logic [2*DW-1:0] acc_i,
  input  logic [2*DW-1:0] prod_i,
  output logic [2*DW-1:0] acc_o
);
  localparam int AW = 2 * DW;
  localparam int HW = DW / 2;

  logic [AW-1:0] sum;
  logic          neg_ovf, pos_ovf;

  assign sum = acc_i + prod_i;
  // bits AW-2..DW-1 must all equal the sign for the sum to fit in DW signed bits
  assign neg_ovf = sum[AW-1] && !(&sum[AW-2:DW-1]);
  assign pos_ovf = !sum[AW-1] && (|sum[AW-2:DW-1]);

  always_comb begin
    acc_o = sum;
    unique case (op_i)
      OP_SMUL, OP_UMUL: acc_o = prod_i;
      OP_MAC: begin
        if (sat_i) begin
          if (sum[AW-1]) acc_o[AW-1 -: HW] = '1;
          else           acc_o[AW-1:DW+HW-1] = '0;
        end
      end
      OP_MACH: begin
        if (sat_i && neg_ovf)
          acc_o = {{{(DW-1){1'b0}}, 1'b1}, 1'b1, {(DW-1){1'b0}}};
        else if (sat_i && pos_ovf)
          acc_o = {{{(DW-1){1'b0}}, 1'b1}, 1'b0, {(DW-1){1'b1}}};
      end
      default: acc_o = sum;
    endcase
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          clear_i,
  input  logic [1:0]    op_i,
  input  logic          sat_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output logic [DW-1:0] acc_hi_o,
  output logic [DW-1:0] acc_lo_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int AW = 2 * DW;

  logic          cap, mul, wr;
  logic          sat_q;
  mac_op_e       op_s;
  logic [AW-1:0] prod, acc_q, acc_nxt;

  mac_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cap_o   (cap),
    .mul_o   (mul),
    .wr_o    (wr),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  mac_mult #(.DW(DW)) i_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .mul_i  (mul),
    .op_i   (mac_op_e'(op_i)),
    .a_i    (opa_i),
    .b_i    (opb_i),
    .op_o   (op_s),
    .prod_o (prod)
  );

  mac_accum #(.DW(DW)) i_accum (
    .op_i   (op_s),
    .sat_i  (sat_q),
    .acc_i  (acc_q),
    .prod_i (prod),
    .acc_o  (acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sat_q <= 1'b0;
      acc_q <= '0;
    end else begin
      if (cap) sat_q <= sat_i;
      // clear outranks a coincident write
      if (clear_i)  acc_q <= '0;
      else if (wr)  acc_q <= acc_nxt;
    end
  end

  assign acc_hi_o = acc_q[AW-1:DW];
  assign acc_lo_o = acc_q[DW-1:0];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic [DW-1:0] acc_hi_o,
  input logic [DW-1:0] acc_lo_o,
  input logic          busy_o,
  input logic          done_o
);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R10
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  // R9
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_hi_o == '0 && acc_lo_o == '0));

  // R11
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({acc_hi_o, acc_lo_o}) |-> (done_o || $past(clear_i)));
endmodule

bind mac_unit mac_unit_chk #(.DW(DW)) i_mac_unit_chk (.*);

// File: tb/test_mac_unit.sv
module test_mac_unit;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          clear = 1'b0;
  logic          sat = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [DW-1:0] a = '0;
  logic [DW-1:0] b = '0;
  logic [DW-1:0] acc_hi, acc_lo;
  logic          busy, done;

  always #5 clk = ~clk;

  mac_unit #(.DW(DW)) i_mac_unit (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .clear_i  (clear),
    .op_i     (op),
    .sat_i    (sat),
    .opa_i    (a),
    .opb_i    (b),
    .acc_hi_o (acc_hi),
    .acc_lo_o (acc_lo),
    .busy_o   (busy),
    .done_o   (done)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  logic [63:0] acc_m = '0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] o, input logic s,
                                        input logic [31:0] x, input logic [31:0] y,
                                        input logic [63:0] acc);
    longint p;
    longint r;
    case (o)
      2'd0: return longint'($signed(x)) * longint'($signed(y));
      2'd1: return {32'b0, x} * {32'b0, y};
      2'd2: begin
        p = longint'($signed(x)) * longint'($signed(y));
        r = longint'(acc) + p;
        if (s) begin
          if (r < 0) r = r | 64'hFFFF0000_00000000;
          else       r = r & 64'h00007FFF_FFFFFFFF;
        end
        return r;
      end
      default: begin
        p = longint'($signed(x[15:0])) * longint'($signed(y[15:0]));
        r = longint'(acc) + p;
        if (s && r < -64'sd2147483648) return {32'd1, 32'h80000000};
        if (s && r > 64'sd2147483647)  return {32'd1, 32'h7FFFFFFF};
        return r;
      end
    endcase
  endfunction

  // driver: clr_at 1 = clear in product cycle, 2 = clear at write edge
  task automatic run_op(input logic [1:0] o, input logic s, input logic [31:0] x,
                        input logic [31:0] y, input int clr_at, input bit restart,
                        input string tag);
    logic [63:0] e;
    if (clr_at == 1) acc_m = '0;
    e = model(o, s, x, y, acc_m);
    if (clr_at == 2) e = '0;
    acc_m = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    op = o; sat = s; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a = ~x; b = ~y; op = ~o; sat = ~s;
    check({tag, " R10 busy after start"}, 64'(busy), 64'd1);
    if (clr_at == 1) clear = 1'b1;
    if (restart) begin start = 1'b1; a = 32'h1111; b = 32'h2222; end
    @(negedge clk);
    clear = 1'b0; start = 1'b0;
    check({tag, " R10 busy second cycle"}, 64'({busy, done}), 64'b10);
    if (clr_at == 2) clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check({tag, " R10 done at write"}, 64'({busy, done}), 64'b01);
    @(negedge clk);
    check({tag, " R10 done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic do_clear(input string tag);
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    acc_m = '0;
    check(tag, {acc_hi, acc_lo}, 64'd0);
  endtask

  // monitor
  always @(negedge clk) begin
    logic [63:0] e;
    string       t;
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R11 unexpected done actual=1 expected=0");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " result"}, {acc_hi, acc_lo}, e);
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
    check("R1 reset flags", 64'({busy, done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(2'd0, 1'b0, 32'hFFFFFFFE, 32'd3, 0, 1'b0, "R2 smul negative");
    run_op(2'd0, 1'b1, 32'h80000000, 32'h80000000, 0, 1'b0, "R2 smul min*min sat ignored");
    run_op(2'd1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 1'b0, "R3 umul max*max");
    run_op(2'd1, 1'b0, 32'h80000000, 32'd2, 0, 1'b0, "R3 umul carry");
    do_clear("R9 clear idle");

    run_op(2'd2, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 1'b0, "R4 mac32 from zero");
    run_op(2'd2, 1'b0, 32'hFFFFFFFF, 32'h00000005, 0, 1'b0, "R4 mac32 negative product");
    run_op(2'd1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 1'b0, "R3 umul preload");
    run_op(2'd2, 1'b0, 32'h80000000, 32'h80000000, 0, 1'b0, "R4 mac32 wrap");

    run_op(2'd0, 1'b0, 32'h80000000, 32'h7FFFFFFF, 0, 1'b0, "R2 smul preload");
    run_op(2'd2, 1'b1, 32'h80000000, 32'h7FFFFFFF, 0, 1'b0, "R5 mac32 sat negative");
    do_clear("R9 clear before R5");
    run_op(2'd2, 1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 1'b0, "R5 mac32 sat positive");

    do_clear("R9 clear before R6");
    run_op(2'd3, 1'b0, 32'hABCD0003, 32'h1234FFFE, 0, 1'b0, "R6 mac16 upper halves ignored");
    run_op(2'd3, 1'b0, 32'h00018000, 32'h00028000, 0, 1'b0, "R6 mac16 min*min");
    run_op(2'd0, 1'b0, 32'h7FFFFFFF, 32'd1, 0, 1'b0, "R2 smul preload max");
    run_op(2'd3, 1'b0, 32'd1, 32'd1, 0, 1'b0, "R6 mac16 no sat passes 2^31");

    run_op(2'd0, 1'b0, 32'h80000000, 32'd1, 0, 1'b0, "R2 smul preload min");
    run_op(2'd3, 1'b1, 32'd1, 32'h0000FFFF, 0, 1'b0, "R7 mac16 sat below range");
    do_clear("R9 clear before R8");
    run_op(2'd3, 1'b1, 32'h00007FFF, 32'h00007FFF, 0, 1'b0, "R8 mac16 sat in range");
    run_op(2'd0, 1'b0, 32'h7FFFFFFF, 32'd1, 0, 1'b0, "R2 smul preload max again");
    run_op(2'd3, 1'b1, 32'd1, 32'd1, 0, 1'b0, "R8 mac16 sat above range");

    run_op(2'd2, 1'b0, 32'd3, 32'd5, 1, 1'b0, "R9 clear in product cycle");
    run_op(2'd2, 1'b0, 32'd3, 32'd5, 2, 1'b0, "R9 clear at write edge");

    run_op(2'd0, 1'b0, 32'd6, 32'd7, 0, 1'b1, "R11 start while busy");
    repeat (3) begin
      @(negedge clk);
      check("R11 no extra busy", 64'({busy, done}), 64'd0);
    end
    check("R11 acc untouched", {acc_hi, acc_lo}, acc_m);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 missing done actual=%0d expected=0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule